// File: doc/BRIEF.md
# Front-End Half-Duplex Link Bus Port

This block is the front-end side of a synchronous, half-duplex, 32-bit shared bus to a link source unit. One bidirectional data bus carries words both ways. The link side chooses the owner through a direction input and an active-low enable input. Two bidirectional active-low qualifiers travel with every word. The transfer strobe marks a valid word. The control qualifier marks that word as a command or status word rather than data. The front-end supplies the bus clock, and every transfer is sampled on its rising edge.

When the link side owns the bus, the block decodes command words from the opcode in their low bits. It then does one of the following: raises a control strobe, arms a status reply, starts streaming event data or block-read data toward the link, or opens a block-write window. In the block-write window, link data words are forwarded to a local sink and a busy line throttles the stream. When the link side hands the bus over, the block waits out a turnaround gap before it drives anything. It holds data words back while the link reports full. An end-of-block command ends any stream, and after that the block stays off the bus.

Top module: `fe_link_port`

## Requirements
- R1: The block recognises a command word only while `lnk_dir` is 0, `lnk_xfer_n` is 0 and `lnk_ctl_n` is 0. The opcode is in bits [3:0] and the argument is in bits [31:4]. The opcodes are: 1 control, 2 status read, 3 end of block, 4 ready to receive event data, 5 start block write, 6 start block read.
- R2: A control command (opcode 1) pulses `ctl_stb` high for exactly one cycle, on the clock after the command. In that cycle `ctl_arg` equals the command's bits [31:4]. There is no data phase.
- R3: The block drives the bus only while `lnk_dir` is 1 and `lnk_ben_n` is 0. After `lnk_dir` rises, at least one full clock passes with `lnk_xfer_n` left undriven before the block strobes any word.
- R4: A status-read command (opcode 2) captures `stat_in` at the command edge. Once the bus is granted, the block returns exactly one word with `lnk_xfer_n`=0 and `lnk_ctl_n`=0. That word is {captured `stat_in`, 4'h2}. Afterwards the block releases the bus unless a stream is open.
- R5: After opcode 4, event words from `evt_data` go out with `lnk_xfer_n`=0 and `lnk_ctl_n`=1, in source order. `evt_take` is high exactly in the cycles where a word is strobed.
- R6: No data word is strobed in a cycle where `lnk_full_n` is 0. A word that is held back stays on `lnk_dat` unchanged until it is sent.
- R7: An end-of-block command (opcode 3) closes any open stream or write window. After it, the block drives nothing and takes no source word, even when the bus is granted.
- R8: After opcode 5, each link data word (`lnk_dir`=0, `lnk_xfer_n`=0, `lnk_ctl_n`=1) appears on `wr_data` with `wr_valid` high one clock later. Data words that arrive outside this window produce no `wr_valid`.
- R9: `fe_busy_n` is 0 exactly when the block-write window is open and `wr_room` is 0.
- R10: After opcode 6, the block streams words from `brd_data` with the same ordering and flow control as event data. It never takes from `evt_data` during a block read.
- R11: Command words with opcodes 0 or 7 to 15 change nothing. They cause no strobe, no stream, no busy and no bus drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock supplied by the front-end |
| rst_n | input | 1 | Active-low asynchronous reset |
| lnk_dat | inout | 32 | Shared data bus |
| lnk_xfer_n | inout | 1 | Active-low word-valid strobe |
| lnk_ctl_n | inout | 1 | Active-low command/status qualifier |
| lnk_dir | input | 1 | 1 hands the bus to the front-end |
| lnk_ben_n | input | 1 | Active-low enable for front-end drivers |
| lnk_full_n | input | 1 | Active-low link-full; pauses data words |
| fe_busy_n | output | 1 | Active-low busy toward the link during block write |
| evt_data | input | 32 | Event source word |
| evt_valid | input | 1 | Event source word present |
| evt_take | output | 1 | Event word consumed this cycle |
| brd_data | input | 32 | Block-read source word |
| brd_valid | input | 1 | Block-read word present |
| brd_take | output | 1 | Block-read word consumed this cycle |
| stat_in | input | 28 | Status payload returned on a status read |
| ctl_stb | output | 1 | One-cycle control command strobe |
| ctl_arg | output | 28 | Argument of the last control command |
| wr_valid | output | 1 | Block-write word valid |
| wr_data | output | 32 | Block-write word |
| wr_room | input | 1 | Sink can accept block-write words |

## Verification
Event and block-read streams run with random gaps in the source and random link-full. This separates correct order and hold behaviour from a design that drops, repeats or alters a word that was held back. Status reads change `stat_in` right after the command, so a design that captures at command time is told apart from one that reads the live value. Each stream ends with an end-of-block command, followed by a granted bus with valid sources, which shows whether the stream really closed. Block writes mix random data gaps with random sink room, which checks the forwarding delay and the busy rule together. Unknown opcodes, a disabled bus enable and the direction turnaround each get directed cases.

// File: rtl/fe_link_pkg.sv
package fe_link_pkg;

   // Opcode values carried in the low bits of a command word (contiguous 1..6)
   localparam int unsigned OPC_CTRL = 1;
   localparam int unsigned OPC_STAT = 2;
   localparam int unsigned OPC_EOB  = 3;
   localparam int unsigned OPC_RDY  = 4;
   localparam int unsigned OPC_BWR  = 5;
   localparam int unsigned OPC_BRD  = 6;
   localparam int unsigned N_OPC    = 6;

   typedef enum logic [1:0] {
      MODE_IDLE = 2'd0,
      MODE_EVT  = 2'd1,
      MODE_BWR  = 2'd2,
      MODE_BRD  = 2'd3
   } lmode_e;

   typedef struct packed {
      logic ctrl;
      logic stat;
      logic eob;
      logic rdy;
      logic bwr;
      logic brd;
   } cmd_hit_t;

endpackage

// File: rtl/fe_link_cmd_dec.sv
module fe_link_cmd_dec
   import fe_link_pkg::*;
#(
   parameter int unsigned OPC_W = 4
) (
   input  logic             rx_own,
   input  logic             xfer_n,
   input  logic             ctl_n,
   input  logic [OPC_W-1:0] opc,
   output cmd_hit_t         hit,
   output logic             data_stb
);

   logic             is_cmd;
   logic [N_OPC-1:0] match;

   assign is_cmd   = rx_own & ~xfer_n & ~ctl_n;
   assign data_stb = rx_own & ~xfer_n & ctl_n;

   generate
      for (genvar i = 0; i < int'(N_OPC); i++) begin : g_match
         assign match[i] = is_cmd && (opc == OPC_W'(i + 1));
      end
   endgenerate

   assign hit.ctrl = match[OPC_CTRL-1];
   assign hit.stat = match[OPC_STAT-1];
   assign hit.eob  = match[OPC_EOB-1];
   assign hit.rdy  = match[OPC_RDY-1];
   assign hit.bwr  = match[OPC_BWR-1];
   assign hit.brd  = match[OPC_BRD-1];

endmodule

// File: rtl/fe_link_turn.sv
module fe_link_turn #(
   parameter int unsigned TURN_IDLE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_fe,
   input  logic ben_n,
   output logic grant
);

   generate
      if (TURN_IDLE < 1) begin : g_bad_turn
         $error("fe_link_turn: TURN_IDLE must be at least 1");
      end

      if (TURN_IDLE == 1) begin : g_flop
         logic dir_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dir_q <= 1'b0;
            else        dir_q <= dir_fe;
         end
         assign grant = dir_fe & dir_q & ~ben_n;
      end else begin : g_cnt
         localparam int unsigned CW = $clog2(TURN_IDLE + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      cnt <= '0;
            else if (!dir_fe)                cnt <= '0;
            else if (cnt != CW'(TURN_IDLE))  cnt <= cnt + 1'b1;
         end
         assign grant = dir_fe & (cnt == CW'(TURN_IDLE)) & ~ben_n;
      end
   endgenerate

endmodule

// File: rtl/fe_link_tx.sv
module fe_link_tx
   import fe_link_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic          grant,
   input  lmode_e        mode,
   input  logic          stat_pend,
   input  logic [DW-1:0] stat_word,
   input  logic [DW-1:0] evt_data,
   input  logic          evt_valid,
   input  logic [DW-1:0] brd_data,
   input  logic          brd_valid,
   input  logic          full_n,
   output logic          oe,
   output logic [DW-1:0] dat_o,
   output logic          xfer_o_n,
   output logic          ctl_o_n,
   output logic          evt_take,
   output logic          brd_take,
   output logic          stat_sent
);

   logic          in_evt, in_brd, strm_valid, send_data;
   logic [DW-1:0] strm_data;

   assign in_evt     = (mode == MODE_EVT);
   assign in_brd     = (mode == MODE_BRD);
   assign strm_valid = (in_evt & evt_valid) | (in_brd & brd_valid);
   assign strm_data  = in_brd ? brd_data : evt_data;

   // Drivers on when granted and there is something this side may say
   assign oe        = grant & (stat_pend | in_evt | in_brd);
   assign stat_sent = oe & stat_pend;
   assign send_data = oe & ~stat_pend & strm_valid & full_n;

   assign dat_o    = stat_pend ? stat_word : strm_data;
   assign xfer_o_n = ~(stat_sent | send_data);
   assign ctl_o_n  = ~stat_pend;

   assign evt_take = send_data & in_evt;
   assign brd_take = send_data & in_brd;

endmodule

// File: rtl/fe_link_port.sv
module fe_link_port
   import fe_link_pkg::*;
#(
   parameter int unsigned DW        = 32,
   parameter int unsigned OPC_W     = 4,
   parameter int unsigned TURN_IDLE = 1,
   localparam int unsigned AW       = DW - OPC_W
) (
   input  logic          clk,
   input  logic          rst_n,
   inout  wire  [DW-1:0] lnk_dat,
   inout  wire           lnk_xfer_n,
   inout  wire           lnk_ctl_n,
   input  logic          lnk_dir,
   input  logic          lnk_ben_n,
   input  logic          lnk_full_n,
   output logic          fe_busy_n,
   input  logic [DW-1:0] evt_data,
   input  logic          evt_valid,
   output logic          evt_take,
   input  logic [DW-1:0] brd_data,
   input  logic          brd_valid,
   output logic          brd_take,
   input  logic [AW-1:0] stat_in,
   output logic          ctl_stb,
   output logic [AW-1:0] ctl_arg,
   output logic          wr_valid,
   output logic [DW-1:0] wr_data,
   input  logic          wr_room
);

   generate
      if (DW <= OPC_W) begin : g_bad_dw
         $error("fe_link_port: DW must exceed OPC_W");
      end
      if (OPC_W < 3) begin : g_bad_opc
         $error("fe_link_port: OPC_W must hold opcodes up to 6");
      end
   endgenerate

   cmd_hit_t      hit;
   logic          data_stb;
   logic          grant;
   logic          oe;
   logic [DW-1:0] dat_o;
   logic          xfer_o_n, ctl_o_n;
   logic          stat_sent;
   logic          stat_pend;
   logic [DW-1:0] stat_word;
   lmode_e        mode;

   fe_link_cmd_dec #(.OPC_W(OPC_W)) u_dec (
      .rx_own   (~lnk_dir),
      .xfer_n   (lnk_xfer_n),
      .ctl_n    (lnk_ctl_n),
      .opc      (lnk_dat[OPC_W-1:0]),
      .hit      (hit),
      .data_stb (data_stb)
   );

   fe_link_turn #(.TURN_IDLE(TURN_IDLE)) u_turn (
      .clk    (clk),
      .rst_n  (rst_n),
      .dir_fe (lnk_dir),
      .ben_n  (lnk_ben_n),
      .grant  (grant)
   );

   fe_link_tx #(.DW(DW)) u_tx (
      .grant     (grant),
      .mode      (mode),
      .stat_pend (stat_pend),
      .stat_word (stat_word),
      .evt_data  (evt_data),
      .evt_valid (evt_valid),
      .brd_data  (brd_data),
      .brd_valid (brd_valid),
      .full_n    (lnk_full_n),
      .oe        (oe),
      .dat_o     (dat_o),
      .xfer_o_n  (xfer_o_n),
      .ctl_o_n   (ctl_o_n),
      .evt_take  (evt_take),
      .brd_take  (brd_take),
      .stat_sent (stat_sent)
   );

   // Transfer mode: end-of-block has priority over any opening command
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mode <= MODE_IDLE;
      else if (hit.eob)  mode <= MODE_IDLE;
      else if (hit.rdy)  mode <= MODE_EVT;
      else if (hit.bwr)  mode <= MODE_BWR;
      else if (hit.brd)  mode <= MODE_BRD;
   end

   // Status reply: payload frozen when the request arrives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_pend <= 1'b0;
         stat_word <= '0;
      end else if (hit.stat) begin
         stat_pend <= 1'b1;
         stat_word <= {stat_in, OPC_W'(OPC_STAT)};
      end else if (stat_sent) begin
         stat_pend <= 1'b0;
      end
   end

   // Control command strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_stb <= 1'b0;
         ctl_arg <= '0;
      end else begin
         ctl_stb <= hit.ctrl;
         if (hit.ctrl) ctl_arg <= lnk_dat[DW-1:OPC_W];
      end
   end

   // Block-write forwarding
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_valid <= 1'b0;
         wr_data  <= '0;
      end else begin
         wr_valid <= data_stb & (mode == MODE_BWR);
         if (data_stb && mode == MODE_BWR) wr_data <= lnk_dat;
      end
   end

   assign fe_busy_n = ~((mode == MODE_BWR) & ~wr_room);

   assign lnk_dat    = oe ? dat_o    : {DW{1'bz}};
   assign lnk_xfer_n = oe ? xfer_o_n : 1'bz;
   assign lnk_ctl_n  = oe ? ctl_o_n  : 1'bz;

endmodule

// File: rtl/fe_link_port_chk.sv
module fe_link_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       lnk_dir,
   input logic       lnk_ben_n,
   input logic       lnk_full_n,
   input logic       lnk_xfer_n,
   input logic       lnk_ctl_n,
   input logic       oe,
   input logic       stat_pend,
   input logic [1:0] mode,
   input logic       ctl_stb,
   input logic       wr_valid,
   input logic       fe_busy_n,
   input logic       wr_room,
   input logic       evt_take,
   input logic       brd_take
);

   p_turn_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lnk_dir) |-> !oe);

   p_off_unless_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!lnk_dir || lnk_ben_n) |-> !oe);

   p_no_data_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && !stat_pend && !lnk_full_n) |-> lnk_xfer_n);

   p_ctl_after_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_stb |-> $past(!lnk_dir && !lnk_xfer_n && !lnk_ctl_n));

   p_wr_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(mode == 2'd2));

   p_busy_rule_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd2 || wr_room) |-> fe_busy_n);

   p_take_needs_stream_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_take || brd_take) |-> (oe && lnk_full_n && mode != 2'd0));

   p_single_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({evt_take, brd_take}));

endmodule

bind fe_link_port fe_link_port_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lnk_dir    (lnk_dir),
   .lnk_ben_n  (lnk_ben_n),
   .lnk_full_n (lnk_full_n),
   .lnk_xfer_n (lnk_xfer_n),
   .lnk_ctl_n  (lnk_ctl_n),
   .oe         (oe),
   .stat_pend  (stat_pend),
   .mode       (mode),
   .ctl_stb    (ctl_stb),
   .wr_valid   (wr_valid),
   .fe_busy_n  (fe_busy_n),
   .wr_room    (wr_room),
   .evt_take   (evt_take),
   .brd_take   (brd_take)
);

// File: tb/tb_fe_link_port.sv
module tb_fe_link_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   wire  [31:0] lnk_dat;
   wire         lnk_xfer_n;
   wire         lnk_ctl_n;
   logic        lnk_dir = 1'b0;
   logic        lnk_ben_n = 1'b1;
   logic        lnk_full_n = 1'b1;
   logic        fe_busy_n;
   logic [31:0] evt_data = '0;
   logic        evt_valid = 1'b0;
   logic        evt_take;
   logic [31:0] brd_data = '0;
   logic        brd_valid = 1'b0;
   logic        brd_take;
   logic [27:0] stat_in = '0;
   logic        ctl_stb;
   logic [27:0] ctl_arg;
   logic        wr_valid;
   logic [31:0] wr_data;
   logic        wr_room = 1'b1;

   logic        tb_drv = 1'b1;
   logic [31:0] tb_dat = '0;
   logic        tb_xfer_n = 1'b1;
   logic        tb_ctl_n = 1'b1;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   assign lnk_dat    = tb_drv ? tb_dat    : 32'bz;
   assign lnk_xfer_n = tb_drv ? tb_xfer_n : 1'bz;
   assign lnk_ctl_n  = tb_drv ? tb_ctl_n  : 1'bz;
   pullup (lnk_xfer_n);
   pullup (lnk_ctl_n);

   always #2 clk = ~clk;

   fe_link_port dut (
      .clk(clk), .rst_n(rst_n), .lnk_dat(lnk_dat), .lnk_xfer_n(lnk_xfer_n),
      .lnk_ctl_n(lnk_ctl_n), .lnk_dir(lnk_dir), .lnk_ben_n(lnk_ben_n),
      .lnk_full_n(lnk_full_n), .fe_busy_n(fe_busy_n), .evt_data(evt_data),
      .evt_valid(evt_valid), .evt_take(evt_take), .brd_data(brd_data),
      .brd_valid(brd_valid), .brd_take(brd_take), .stat_in(stat_in),
      .ctl_stb(ctl_stb), .ctl_arg(ctl_arg), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_room(wr_room)
   );

   function automatic logic [31:0] word_of(input logic [31:0] base, input int k);
      return base + 32'(k) * 32'h9E37_79B9;
   endfunction

   function automatic logic [31:0] cmd_word(input logic [27:0] arg, input logic [3:0] opc);
      return {arg, opc};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_cmd(input logic [31:0] w);
      @(negedge clk);
      tb_drv = 1'b1; tb_dat = w; tb_xfer_n = 1'b0; tb_ctl_n = 1'b0;
      @(negedge clk);
      tb_xfer_n = 1'b1; tb_ctl_n = 1'b1; tb_dat = $urandom;
   endtask

   task automatic set_src(input bit brd, input logic v, input logic [31:0] d);
      if (brd) begin brd_valid = v; brd_data = d; evt_valid = 1'b0; end
      else     begin evt_valid = v; evt_data = d; brd_valid = 1'b0; end
   endtask

   task automatic release_bus();
      @(negedge clk);
      lnk_dir = 1'b0; lnk_ben_n = 1'b1; tb_drv = 1'b1;
      lnk_full_n = 1'b1; evt_valid = 1'b0; brd_valid = 1'b0;
   endtask

   // Bus granted with both sources offering words; the block must stay quiet
   task automatic check_silent(input int cycles, input string req);
      @(negedge clk);
      tb_drv = 1'b0; lnk_dir = 1'b1; lnk_ben_n = 1'b0;
      evt_valid = 1'b1; brd_valid = 1'b1; lnk_full_n = 1'b1;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk); #1;
         chk({req, " no strobe"}, 32'(lnk_xfer_n), 32'd1);
         chk({req, " no take"}, 32'({evt_take, brd_take}), 32'd0);
      end
      release_bus();
   endtask

   task automatic run_stream(input bit brd, input int n, input logic [31:0] base);
      int   got = 0;
      int   cyc = 0;
      logic v = 1'b1;
      logic held = 1'b1;
      logic exp_send;
      string tag;
      tag = brd ? "R10" : "R5";
      @(negedge clk);
      tb_drv = 1'b0; lnk_dir = 1'b1; lnk_ben_n = 1'b0; lnk_full_n = 1'b1;
      set_src(brd, 1'b1, word_of(base, 0));
      #1;
      chk("R3 turnaround gap", 32'(lnk_xfer_n), 32'd1);
      chk("R3 no take in gap", 32'({evt_take, brd_take}), 32'd0);
      while (got < n && cyc < 4000) begin
         @(negedge clk);
         cyc++;
         v = held ? 1'b1 : ($urandom % 4 != 0);
         lnk_full_n = ($urandom % 3 != 0);
         set_src(brd, v, word_of(base, got));
         #1;
         exp_send = v && lnk_full_n;
         chk("R6 strobe versus full", 32'(lnk_xfer_n), 32'(!exp_send));
         chk({tag, " take"}, 32'({evt_take, brd_take}),
             exp_send ? (brd ? 32'd1 : 32'd2) : 32'd0);
         if (v && !lnk_full_n)
            chk("R6 held word unchanged", lnk_dat, word_of(base, got));
         if (exp_send) begin
            chk({tag, " word order"}, lnk_dat, word_of(base, got));
            chk({tag, " data qualifier"}, 32'(lnk_ctl_n), 32'd1);
            got++;
         end
         held = v && !exp_send;
      end
      chk({tag, " all words delivered"}, 32'(got), 32'(n));
      release_bus();
   endtask

   task automatic do_event(input int n);
      send_cmd(cmd_word(28'($urandom), 4'h4));
      // Direction given but bus enable held off: no drive
      @(negedge clk);
      tb_drv = 1'b0; lnk_dir = 1'b1; lnk_ben_n = 1'b1; evt_valid = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         chk("R3 enable off no strobe", 32'(lnk_xfer_n), 32'd1);
         chk("R3 enable off no take", 32'(evt_take), 32'd0);
      end
      release_bus();
      run_stream(1'b0, n, $urandom);
      send_cmd(cmd_word(28'($urandom), 4'h3));
      check_silent(3, "R7 after event");
   endtask

   task automatic do_bread(input int n);
      send_cmd(cmd_word(28'($urandom), 4'h6));
      run_stream(1'b1, n, $urandom);
      send_cmd(cmd_word(28'($urandom), 4'h3));
      check_silent(3, "R7 after block read");
   endtask

   task automatic do_status();
      logic [27:0] s;
      s = 28'($urandom);
      stat_in = s;
      send_cmd(cmd_word(28'($urandom), 4'h2));
      stat_in = ~s;
      @(negedge clk);
      tb_drv = 1'b0; lnk_dir = 1'b1; lnk_ben_n = 1'b0;
      #1;
      chk("R3 status turnaround gap", 32'(lnk_xfer_n), 32'd1);
      @(negedge clk); #1;
      chk("R4 status strobe", 32'(lnk_xfer_n), 32'd0);
      chk("R4 status qualifier", 32'(lnk_ctl_n), 32'd0);
      chk("R4 status word", lnk_dat, {s, 4'h2});
      @(negedge clk); #1;
      chk("R4 single status word", 32'(lnk_xfer_n), 32'd1);
      release_bus();
   endtask

   task automatic do_control();
      logic [27:0] a;
      a = 28'($urandom);
      send_cmd(cmd_word(a, 4'h1));
      #1;
      chk("R2 control strobe", 32'(ctl_stb), 32'd1);
      chk("R2 control argument", 32'(ctl_arg), 32'(a));
      @(negedge clk); #1;
      chk("R2 strobe one cycle", 32'(ctl_stb), 32'd0);
   endtask

   task automatic do_bwrite(input int n);
      logic        pv = 1'b0;
      logic [31:0] pd = '0;
      logic        v;
      send_cmd(cmd_word(28'($urandom), 4'h5));
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         v = ($urandom % 3 != 0);
         wr_room = $urandom % 2;
         tb_dat = $urandom; tb_xfer_n = !v; tb_ctl_n = 1'b1;
         #1;
         chk("R9 busy follows room", 32'(fe_busy_n), 32'(wr_room));
         chk("R8 write valid", 32'(wr_valid), 32'(pv));
         if (pv) chk("R8 write data", wr_data, pd);
         pv = v; pd = tb_dat;
      end
      @(negedge clk);
      tb_xfer_n = 1'b1;
      #1;
      chk("R8 last write valid", 32'(wr_valid), 32'(pv));
      if (pv) chk("R8 last write data", wr_data, pd);
      send_cmd(cmd_word(28'($urandom), 4'h3));
      wr_room = 1'b0;
      #1;
      chk("R9 no busy after end of block", 32'(fe_busy_n), 32'd1);
      @(negedge clk);
      tb_dat = $urandom; tb_xfer_n = 1'b0; tb_ctl_n = 1'b1;
      @(negedge clk);
      tb_xfer_n = 1'b1;
      #1;
      chk("R8 data outside window ignored", 32'(wr_valid), 32'd0);
      wr_room = 1'b1;
   endtask

   task automatic do_unknown();
      logic [3:0] op;
      op = ($urandom % 4 == 0) ? 4'h0 : 4'(7 + $urandom % 9);
      wr_room = 1'b0;
      send_cmd(cmd_word(28'($urandom), op));
      #1;
      chk("R11 unknown no strobe", 32'(ctl_stb), 32'd0);
      chk("R11 unknown no busy", 32'(fe_busy_n), 32'd1);
      wr_room = 1'b1;
      check_silent(2, "R11 unknown opcode");
   endtask

   initial begin
      process::self().srandom(32'd7071);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("reset ctl_stb", 32'(ctl_stb), 32'd0);
      chk("reset wr_valid", 32'(wr_valid), 32'd0);
      chk("reset busy", 32'(fe_busy_n), 32'd1);
      chk("reset takes", 32'({evt_take, brd_take}), 32'd0);

      // R1 directed: each opcode decoded from the low four bits
      do_control();
      do_control();
      do_status();
      do_event(40);
      do_bread(40);
      do_bwrite(40);
      do_unknown();
      do_unknown();
      do_unknown();

      for (int r = 0; r < 10; r++) begin
         case ($urandom % 5)
            0: do_control();
            1: do_status();
            2: do_event(8 + $urandom % 16);
            3: do_bread(8 + $urandom % 16);
            default: do_bwrite(8 + $urandom % 16);
         endcase
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule